// File: doc/BRIEF.md
# Frame Safety-Byte CRC-8 Sequencer

This block computes the CRC-8 safety byte that closes the payload of data frames on a serial lighting bus. A frame begins with a one-cycle `start` pulse. On that pulse the block latches a frame-type code, a data length count, a check-mode flag and, for checking, the safety byte received from the wire. The block then takes payload bytes through a valid/ready handshake, one byte per clock. The CRC register is updated eight bits at a time by an unrolled parallel step.

The frame type sets how many bytes the block accepts. For the power-mode frame, the block appends a zero padding byte by itself. Once the last covered byte has entered the CRC, the block pulses `done` and presents the result on `crc_out`. In check mode it also raises `crc_ok` when the result equals the latched received byte. It drops `in_ready` when the byte count is reached and when the frame type is unknown. An unknown frame type also raises `err`. Header decoding and the serial line itself are handled elsewhere.

Top module: `frame_crc8_seq`

## Requirements
- R1: While reset is asserted and after it is released, `in_ready`, `done`, `err` and `crc_ok` are 0 and `crc_out` is 0x00.
- R2: The CRC is shifted MSB first with polynomial x^8+x^4+x^3+x^2+1 (0x1D). It is seeded with 0xFF at every `start`, uses no reflection, and applies a final XOR of 0x00 by default. The nine ASCII bytes "123456789" give 0xB4.
- R3: Frame type code 0 (duty-cycle update) accepts exactly 32 bytes: the 16 duty words of outputs 0 to 15 in order, each as its high byte then its low byte. The CRC covers all 32 bytes.
- R4: Frame type code 1 (power-mode change) accepts exactly one byte. It then holds `in_ready` low for one cycle while it folds in a 0x00 byte. `done` comes one cycle later than for the other types, with the CRC over the mode byte followed by 0x00.
- R5: Frame type codes 2 (register write) and 3 (register read) accept one start-address byte followed by DLC 16-bit words, high byte first. That is 1+2*DLC bytes, DLC from 0 to 15.
- R6: `done` is a one-cycle pulse in the cycle after the last covered byte is consumed. `crc_out` changes only together with `done` and holds its value until the next `done`.
- R7: Once the frame's byte count is reached, `in_ready` stays low until the next `start`. Bytes offered meanwhile change neither `crc_out` nor `done`.
- R8: Cycles with `in_valid` low leave the CRC unchanged, so stalls between bytes do not alter the result.
- R9: In check mode, `crc_ok` pulses with `done` when the final CRC equals the latched received byte. On a mismatch, or when check mode is off, `crc_ok` stays 0.
- R10: Frame type codes 4 to 7 are unknown. From the cycle after `start`, `err` is 1 until the next `start`, `in_ready` stays low and no `done` occurs.
- R11: A `start` in the middle of a frame discards the partial CRC and begins the new frame from the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a frame and latches the frame setup |
| frame_type | input | 3 | Frame-type code (0 duty, 1 power mode, 2 write, 3 read) |
| dlc | input | 4 | Data length count in 16-bit words for register frames |
| check_en | input | 1 | 1 selects check mode |
| rx_crc | input | 8 | Received safety byte for check mode |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block consumes the byte this cycle if `in_valid` |
| done | output | 1 | One-cycle end-of-frame pulse |
| crc_out | output | 8 | Final CRC of the last completed frame |
| crc_ok | output | 1 | Check-mode match, pulsed with `done` |
| err | output | 1 | Unknown frame type latched |

## Verification
The update step is checked against the well-known nine-byte ASCII vector, which catches a wrong polynomial, seed or bit order. A 32-byte duty frame fed with stall cycles separates a correct byte count and handshake from one that drops or repeats bytes. A power-mode frame shows whether the internal zero byte is folded in and whether `done` comes one cycle later. Register frames with DLC 0 and DLC 15 probe both ends of the length range. A mid-frame restart, extra bytes after completion and an unknown type code show that nothing stale leaks into `crc_out`. Check-mode runs with a correct and with a flipped received byte tell the compare apart from a stuck flag.

// File: rtl/frame_crc8_pkg.sv
package frame_crc8_pkg;

    localparam logic [2:0] FT_DUTY  = 3'd0;
    localparam logic [2:0] FT_PMODE = 3'd1;
    localparam logic [2:0] FT_WREG  = 3'd2;
    localparam logic [2:0] FT_RREG  = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAD  = 2'd2
    } phase_e;

endpackage

// File: rtl/crc8_step.sv
module crc8_step #(
    parameter logic [7:0] POLY = 8'h1D
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] byte_in,
    output logic [7:0] crc_nxt
);
    logic [7:0] stage [0:8];

    assign stage[0] = crc_in ^ byte_in;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = {stage[b][6:0], 1'b0} ^ (stage[b][7] ? POLY : 8'h00);
    end

    assign crc_nxt = stage[8];
endmodule

// File: rtl/frame_len_dec.sv
module frame_len_dec
    import frame_crc8_pkg::*;
#(
    parameter int DLC_W      = 4,
    parameter int DUTY_CH    = 16,
    parameter int WORD_BYTES = 2,
    parameter int CNT_W      = 6
) (
    input  logic [2:0]       ftype,
    input  logic [DLC_W-1:0] dlc,
    output logic [CNT_W-1:0] n_bytes,
    output logic             pad,
    output logic             known
);
    always_comb begin
        n_bytes = CNT_W'(1);
        pad     = 1'b0;
        known   = 1'b1;
        case (ftype)
            FT_DUTY:  n_bytes = CNT_W'(DUTY_CH * WORD_BYTES);
            FT_PMODE: pad     = 1'b1;
            FT_WREG,
            FT_RREG:  n_bytes = CNT_W'(1 + WORD_BYTES * int'(dlc));
            default:  known   = 1'b0;
        endcase
    end
endmodule

// File: rtl/frame_crc8_seq.sv
module frame_crc8_seq
    import frame_crc8_pkg::*;
#(
    parameter int         DLC_W      = 4,
    parameter int         DUTY_CH    = 16,
    parameter int         WORD_BYTES = 2,
    parameter logic [7:0] POLY       = 8'h1D,
    parameter logic [7:0] SEED       = 8'hFF,
    parameter logic [7:0] XOR_OUT    = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       frame_type,
    input  logic [DLC_W-1:0] dlc,
    input  logic             check_en,
    input  logic [7:0]       rx_crc,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             done,
    output logic [7:0]       crc_out,
    output logic             crc_ok,
    output logic             err
);
    localparam int DUTY_BYTES = DUTY_CH * WORD_BYTES;
    localparam int REG_BYTES  = 1 + WORD_BYTES * ((1 << DLC_W) - 1);
    localparam int MAX_BYTES  = (DUTY_BYTES > REG_BYTES) ? DUTY_BYTES : REG_BYTES;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pad;
        logic [7:0]       crc;
        logic             chk;
        logic [7:0]       rx;
        logic [7:0]       res;
        logic             done;
        logic             ok;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0] dec_bytes;
    logic             dec_pad;
    logic             dec_known;
    logic [7:0]       step_in;
    logic [7:0]       step_out;
    logic [7:0]       fin_val;
    logic             accept;
    logic             finish;

    frame_len_dec #(
        .DLC_W      (DLC_W),
        .DUTY_CH    (DUTY_CH),
        .WORD_BYTES (WORD_BYTES),
        .CNT_W      (CNT_W)
    ) len_i (
        .ftype   (frame_type),
        .dlc     (dlc),
        .n_bytes (dec_bytes),
        .pad     (dec_pad),
        .known   (dec_known)
    );

    assign step_in = (s_q.phase == PH_PAD) ? 8'h00 : in_data;

    crc8_step #(.POLY(POLY)) step_i (
        .crc_in  (s_q.crc),
        .byte_in (step_in),
        .crc_nxt (step_out)
    );

    assign in_ready = (s_q.phase == PH_DATA);
    assign accept   = in_valid && in_ready;
    assign fin_val  = step_out ^ XOR_OUT;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ok   = 1'b0;
        finish   = 1'b0;
        if (start) begin
            s_d.crc   = SEED;
            s_d.cnt   = dec_bytes;
            s_d.pad   = dec_pad;
            s_d.chk   = check_en;
            s_d.rx    = rx_crc;
            s_d.err   = !dec_known;
            s_d.phase = dec_known ? PH_DATA : PH_IDLE;
        end else begin
            case (s_q.phase)
                PH_DATA: begin
                    if (accept) begin
                        s_d.crc = step_out;
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                        if (s_q.cnt == CNT_W'(1)) begin
                            if (s_q.pad) s_d.phase = PH_PAD;
                            else         finish    = 1'b1;
                        end
                    end
                end
                PH_PAD: begin
                    s_d.crc = step_out;
                    finish  = 1'b1;
                end
                default: ;
            endcase
            if (finish) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
                s_d.res   = fin_val;
                s_d.ok    = s_q.chk && (fin_val == s_q.rx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, pad: 1'b0, crc: SEED, chk: 1'b0,
                     rx: 8'h00, res: 8'h00, done: 1'b0, ok: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done    = s_q.done;
    assign crc_out = s_q.res;
    assign crc_ok  = s_q.ok;
    assign err     = s_q.err;
endmodule

// File: rtl/frame_crc8_chk.sv
module frame_crc8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       done,
    input logic [7:0] crc_out,
    input logic       crc_ok,
    input logic       err
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_out) |-> done);

    // R7
    closed_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R9
    ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done);

    // R10
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!in_ready && !done));
endmodule

bind frame_crc8_seq frame_crc8_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .done     (done),
    .crc_out  (crc_out),
    .crc_ok   (crc_ok),
    .err      (err)
);

// File: tb/frame_crc8_seq_tb_top.sv
module frame_crc8_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] frame_type = 3'd0;
    logic [3:0] dlc = 4'd0;
    logic       check_en = 1'b0;
    logic [7:0] rx_crc = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, done, crc_ok, err;
    logic [7:0] crc_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] buf_q [0:63];
    int rejects;

    always #5 clk = ~clk;

    frame_crc8_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_type(frame_type),
        .dlc(dlc), .check_en(check_en), .rx_crc(rx_crc), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .done(done), .crc_out(crc_out),
        .crc_ok(crc_ok), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ buf_q[i];
            for (int b = 0; b < 8; b++)
                c = c[7] ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

    task automatic do_start(input logic [2:0] ft, input logic [3:0] l,
                            input logic ce, input logic [7:0] rx);
        @(negedge clk);
        start = 1'b1; frame_type = ft; dlc = l; check_en = ce; rx_crc = rx;
        @(negedge clk);
        start = 1'b0;
    endtask

    // called just after a negedge; returns at the negedge after the last accept
    task automatic feed(input int n, input bit stall);
        rejects = 0;
        for (int i = 0; i < n; i++) begin
            if (stall && (i % 3 == 1)) begin
                in_valid = 1'b0; in_data = 8'hA5;
                @(negedge clk);
            end
            if (!in_ready) rejects++;
            in_valid = 1'b1; in_data = buf_q[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 in_ready", in_ready, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 crc_ok", crc_ok, 0);
        chk("R1 crc_out", crc_out, 8'h00);
    endtask

    task automatic t_vector;
        string s = "123456789";
        for (int i = 0; i < 9; i++) buf_q[i] = s[i];
        do_start(3'd2, 4'd4, 1'b0, 8'h00);
        feed(9, 1'b0);
        chk("R5 write bytes accepted", rejects, 0);
        chk("R6 done pulse", done, 1);
        chk("R2 ascii vector", crc_out, 8'hB4);
        chk("R9 no ok in generate mode", crc_ok, 0);
        @(negedge clk);
        chk("R6 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk("R6 result held", crc_out, 8'hB4);
    endtask

    task automatic t_duty;
        logic [7:0] e;
        for (int i = 0; i < 32; i++) buf_q[i] = 8'(i * 7 + 3);
        e = ref_crc(32);
        do_start(3'd0, 4'd9, 1'b0, 8'h00);
        feed(32, 1'b1);
        chk("R3 R8 duty bytes accepted", rejects, 0);
        chk("R3 duty done", done, 1);
        chk("R3 R8 duty crc with stalls", crc_out, e);
        chk("R7 ready low after count", in_ready, 0);
    endtask

    task automatic t_pmode;
        logic [7:0] e;
        buf_q[0] = 8'h5A; buf_q[1] = 8'h00;
        e = ref_crc(2);
        do_start(3'd1, 4'd7, 1'b0, 8'h00);
        feed(1, 1'b0);
        chk("R4 no done before pad", done, 0);
        chk("R4 ready low in pad", in_ready, 0);
        @(negedge clk);
        chk("R4 done after pad", done, 1);
        chk("R4 crc with zero pad", crc_out, e);
    endtask

    task automatic t_read_bounds;
        buf_q[0] = 8'h3C;
        do_start(3'd3, 4'd0, 1'b0, 8'h00);
        feed(1, 1'b0);
        chk("R5 read dlc0 done", done, 1);
        chk("R5 read dlc0 crc", crc_out, ref_crc(1));
        for (int i = 0; i < 31; i++) buf_q[i] = 8'(255 - i * 5);
        do_start(3'd3, 4'd15, 1'b0, 8'h00);
        feed(30, 1'b0);
        chk("R5 dlc15 no early done", done, 0);
        chk("R5 dlc15 still ready", in_ready, 1);
        in_valid = 1'b1; in_data = buf_q[30];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 read dlc15 done", done, 1);
        chk("R5 read dlc15 crc", crc_out, ref_crc(31));
    endtask

    task automatic t_extra;
        logic [7:0] held;
        logic seen;
        held = crc_out;
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_data = 8'(i + 17);
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        in_valid = 1'b0;
        chk("R7 extra bytes no done", seen, 0);
        chk("R7 extra bytes crc unchanged", crc_out, held);
        chk("R7 ready stays low", in_ready, 0);
    endtask

    task automatic t_check;
        logic [7:0] e;
        buf_q[0] = 8'h10;
        for (int i = 1; i < 5; i++) buf_q[i] = 8'(i * 33);
        e = ref_crc(5);
        do_start(3'd2, 4'd2, 1'b1, e);
        feed(5, 1'b0);
        chk("R9 match done", done, 1);
        chk("R9 match ok", crc_ok, 1);
        @(negedge clk);
        chk("R9 ok pulse ends", crc_ok, 0);
        do_start(3'd2, 4'd2, 1'b1, e ^ 8'h01);
        feed(5, 1'b0);
        chk("R9 mismatch done", done, 1);
        chk("R9 mismatch ok low", crc_ok, 0);
    endtask

    task automatic t_unknown;
        logic seen;
        seen = 1'b0;
        do_start(3'd6, 4'd3, 1'b0, 8'h00);
        chk("R10 err set", err, 1);
        chk("R10 ready low", in_ready, 0);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_data = 8'hEE;
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        in_valid = 1'b0;
        chk("R10 no done", seen, 0);
        chk("R10 err held", err, 1);
        do_start(3'd3, 4'd0, 1'b0, 8'h00);
        chk("R10 err cleared by known start", err, 0);
        buf_q[0] = 8'h01;
        feed(1, 1'b0);
        chk("R10 recovery crc", crc_out, ref_crc(1));
    endtask

    task automatic t_restart;
        for (int i = 0; i < 5; i++) buf_q[i] = 8'hC0 + 8'(i);
        do_start(3'd0, 4'd0, 1'b0, 8'h00);
        feed(5, 1'b0);
        buf_q[0] = 8'h22; buf_q[1] = 8'h9B; buf_q[2] = 8'h04;
        do_start(3'd2, 4'd1, 1'b0, 8'h00);
        feed(3, 1'b0);
        chk("R11 restart done", done, 1);
        chk("R11 restart crc from seed", crc_out, ref_crc(3));
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vector();
        t_duty();
        t_extra();
        t_pmode();
        t_read_bounds();
        t_check();
        t_unknown();
        t_restart();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule